// File: doc/BRIEF.md
# Four-Entry Address Translator with Page-Table Walk

This block turns a 16-bit virtual address into a physical address. The upper four address bits select a virtual page. The low twelve bits are the byte offset within a 4096-byte page, and they pass straight through. A small fully associative buffer of four recent translations is searched first. When it holds the page, the stored physical page number is returned on the next cycle.

When the buffer does not hold the page, the block reads a 16-entry on-chip page table. If that entry is resident, its mapping is copied into the buffer. If the entry says the page lives on disk, the block takes the next free physical frame from a counter, writes that frame into the page table, and installs the new mapping in the buffer. Both miss paths report a miss; the disk case also reports a page fault.

The buffer slot for a new mapping is the lowest-numbered empty slot, or the least recently used slot when all four are full. A load port lets the surrounding system set the buffer, the page table and the free-frame counter before traffic starts.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0, and every buffer slot is empty, so the first request for any page reports a miss. The page table keeps its contents across reset, and the free-frame counter resets to 0.
- R2: A request whose page (vaddr[15:12]) is in a valid buffer slot responds one cycle after acceptance. The response has rsp_hit=1, rsp_miss=0, rsp_fault=0 and rsp_paddr = {stored page number, vaddr[11:0]}.
- R3: A buffer miss on a resident page-table entry responds two cycles after acceptance. The response has rsp_miss=1, rsp_fault=0, rsp_hit=0 and paddr = {table page number, offset}. The mapping is then installed, so a repeat request hits.
- R4: A buffer miss on a page-table entry marked on disk (valid=0) responds two cycles after acceptance with rsp_miss=1 and rsp_fault=1. The physical page is the free-frame counter value, and the counter then increments, so successive faults get consecutive frames. The page table is updated, so a later buffer miss on that page reports no fault and returns the same frame.
- R5: A fill goes into the lowest-numbered invalid slot when one exists, before any valid slot is evicted.
- R6: With all slots valid, a fill evicts the least recently used slot. Hits and fills both count as uses. After reset, slot i has recency rank 3-i, which makes slot 0 the oldest.
- R7: req_ready is 0 during the cycle of a page-table access. A request presented while req_ready is 0 is ignored and produces no response.
- R8: Every response has exactly one of rsp_hit or rsp_miss set, and rsp_fault is set only together with rsp_miss.
- R9: rsp_paddr[11:0] equals the offset of the accepted request.
- R10: While the block is idle, the load port writes a buffer slot (valid, page tag, physical page), a page-table entry (valid, physical page), and the free-frame counter. Later translations use the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address of the request |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 20 | Physical address {page, offset} |
| rsp_hit | output | 1 | Buffer hit |
| rsp_miss | output | 1 | Buffer miss |
| rsp_fault | output | 1 | Page fault, a frame was allocated |
| ld_tlb_we | input | 1 | Load one buffer slot |
| ld_tlb_idx | input | 2 | Slot number to load |
| ld_tlb_valid | input | 1 | Valid bit for the loaded slot |
| ld_tlb_vpn | input | 4 | Virtual page tag for the loaded slot |
| ld_tlb_ppn | input | 8 | Physical page for the loaded slot |
| ld_pt_we | input | 1 | Load one page-table entry |
| ld_pt_vpn | input | 4 | Page-table entry index |
| ld_pt_valid | input | 1 | 1 = resident, 0 = on disk |
| ld_pt_ppn | input | 8 | Physical page for the entry |
| ld_frame_we | input | 1 | Load the free-frame counter |
| ld_frame_ppn | input | 8 | First free physical page |

## Verification
The assertions assume that the load port is used only while the block is idle and no request is being presented. They also assume the loaded buffer never holds two valid slots with the same tag, so at most one slot can match. The bench applies every load before traffic, or after a drained response with req_valid low, and its loaded tags are distinct. New requests are driven only when req_ready was seen high at the falling edge. The single exception is a deliberate request held during the page-table cycle to test that it is ignored.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_t;

endpackage

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_en,
  input  logic [IDX_W-1:0] use_idx,
  output logic [IDX_W-1:0] victim_idx
);

  logic [IDX_W-1:0] age [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= IDX_W'(N - 1 - i);
    end else if (use_en) begin
      for (int i = 0; i < N; i++) begin
        if (use_idx == IDX_W'(i))
          age[i] <= '0;
        else if (age[i] < age[use_idx])
          age[i] <= age[i] + {{(IDX_W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++)
      if (age[i] == IDX_W'(N - 1)) victim_idx = IDX_W'(i);
  end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 4,
  parameter int VPN_W = 4,
  parameter int PPN_W = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn
);

  logic [N-1:0]     slot_v;
  logic [VPN_W-1:0] slot_tag [N];
  logic [PPN_W-1:0] slot_ppn [N];
  logic [N-1:0]     match;

  always_ff @(posedge clk) begin
    if (rst) slot_v <= '0;
    else if (wr_en) slot_v[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_tag[wr_idx] <= wr_vpn;
      slot_ppn[wr_idx] <= wr_ppn;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = slot_v[g] && (slot_tag[g] == lk_vpn);
  end

  always_comb begin
    lk_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) lk_idx = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!slot_v[i]) free_idx = IDX_W'(i);
  end

  assign lk_hit   = |match;
  assign lk_ppn   = slot_ppn[lk_idx];
  assign free_any = ~&slot_v;

endmodule

// File: rtl/tlb_ptab.sv
module tlb_ptab #(
  parameter int VPN_W = 4,
  parameter int PPN_W = 8,
  localparam int DEPTH = 1 << VPN_W
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [VPN_W-1:0] rd_addr,
  output logic             rd_valid,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_addr,
  input  logic             wr_valid,
  input  logic [PPN_W-1:0] wr_ppn
);

  logic [PPN_W:0] mem [DEPTH];
  logic [PPN_W:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_valid, wr_ppn};
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_valid = rd_q[PPN_W];
  assign rd_ppn   = rd_q[PPN_W-1:0];

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 8,
  parameter int ENTRIES = 4,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  input  logic             ld_tlb_we,
  input  logic [IDX_W-1:0] ld_tlb_idx,
  input  logic             ld_tlb_valid,
  input  logic [VPN_W-1:0] ld_tlb_vpn,
  input  logic [PPN_W-1:0] ld_tlb_ppn,
  input  logic             ld_pt_we,
  input  logic [VPN_W-1:0] ld_pt_vpn,
  input  logic             ld_pt_valid,
  input  logic [PPN_W-1:0] ld_pt_ppn,
  input  logic             ld_frame_we,
  input  logic [PPN_W-1:0] ld_frame_ppn
);

  walk_state_t      state;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [PPN_W-1:0] frame_q;

  logic             accept, walking;
  logic [VPN_W-1:0] req_vpn;

  logic             cam_hit, cam_free_any;
  logic [IDX_W-1:0] cam_idx, cam_free_idx;
  logic [PPN_W-1:0] cam_ppn;

  logic             pt_valid;
  logic [PPN_W-1:0] pt_ppn;

  logic [IDX_W-1:0] victim_idx, fill_idx;
  logic [PPN_W-1:0] fill_ppn;

  logic             cw_en, cw_valid;
  logic [IDX_W-1:0] cw_idx;
  logic [VPN_W-1:0] cw_vpn;
  logic [PPN_W-1:0] cw_ppn;

  logic             pw_en, pw_valid;
  logic [VPN_W-1:0] pw_addr;
  logic [PPN_W-1:0] pw_ppn;

  logic             use_en;
  logic [IDX_W-1:0] use_idx;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign walking   = (state == ST_WALK);
  assign req_vpn   = req_vaddr[VA_W-1:OFF_W];

  assign fill_idx  = cam_free_any ? cam_free_idx : victim_idx;
  assign fill_ppn  = pt_valid ? pt_ppn : frame_q;

  always_comb begin
    if (walking) begin
      cw_en    = 1'b1;
      cw_idx   = fill_idx;
      cw_valid = 1'b1;
      cw_vpn   = vpn_q;
      cw_ppn   = fill_ppn;
    end else begin
      cw_en    = ld_tlb_we;
      cw_idx   = ld_tlb_idx;
      cw_valid = ld_tlb_valid;
      cw_vpn   = ld_tlb_vpn;
      cw_ppn   = ld_tlb_ppn;
    end
  end

  always_comb begin
    if (walking && !pt_valid) begin
      pw_en    = 1'b1;
      pw_addr  = vpn_q;
      pw_valid = 1'b1;
      pw_ppn   = frame_q;
    end else begin
      pw_en    = ld_pt_we && !walking;
      pw_addr  = ld_pt_vpn;
      pw_valid = ld_pt_valid;
      pw_ppn   = ld_pt_ppn;
    end
  end

  assign use_en  = walking || (accept && cam_hit);
  assign use_idx = walking ? fill_idx : cam_idx;

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk      (clk),
    .rst      (rst),
    .lk_vpn   (req_vpn),
    .lk_hit   (cam_hit),
    .lk_idx   (cam_idx),
    .lk_ppn   (cam_ppn),
    .free_any (cam_free_any),
    .free_idx (cam_free_idx),
    .wr_en    (cw_en),
    .wr_idx   (cw_idx),
    .wr_valid (cw_valid),
    .wr_vpn   (cw_vpn),
    .wr_ppn   (cw_ppn)
  );

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .use_en     (use_en),
    .use_idx    (use_idx),
    .victim_idx (victim_idx)
  );

  tlb_ptab #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ptab (
    .clk      (clk),
    .rd_en    (accept),
    .rd_addr  (req_vpn),
    .rd_valid (pt_valid),
    .rd_ppn   (pt_ppn),
    .wr_en    (pw_en),
    .wr_addr  (pw_addr),
    .wr_valid (pw_valid),
    .wr_ppn   (pw_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else if (walking) begin
      state <= ST_IDLE;
    end else if (accept && !cam_hit) begin
      state <= ST_WALK;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      vpn_q <= req_vpn;
      off_q <= req_vaddr[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      frame_q <= '0;
    else if (walking && !pt_valid)
      frame_q <= frame_q + {{(PPN_W-1){1'b0}}, 1'b1};
    else if (ld_frame_we && !walking)
      frame_q <= ld_frame_ppn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (walking) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_miss  <= 1'b1;
        rsp_fault <= !pt_valid;
        rsp_paddr <= {fill_ppn, off_q};
      end else if (accept && cam_hit) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_miss  <= 1'b0;
        rsp_fault <= 1'b0;
        rsp_paddr <= {cam_ppn, req_vaddr[OFF_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 12,
  parameter int PA_W  = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault
);

  logic [OFF_W-1:0] seen_off;

  always_ff @(posedge clk) begin
    if (rst) seen_off <= '0;
    else if (req_valid && req_ready) seen_off <= req_vaddr[OFF_W-1:0];
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_miss)); // R8

  AST_FAULT_NEEDS_MISS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> rsp_miss); // R8

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid && rsp_hit) || !req_ready); // R2

  AST_WALK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> rsp_valid && rsp_miss && req_ready); // R3

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready) || $past(!req_ready)); // R7

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_paddr[OFF_W-1:0] == seen_off); // R9

endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_fault (rsp_fault)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [19:0] rsp_paddr;
  logic        ld_tlb_we = 1'b0, ld_tlb_valid = 1'b0;
  logic [1:0]  ld_tlb_idx = '0;
  logic [3:0]  ld_tlb_vpn = '0;
  logic [7:0]  ld_tlb_ppn = '0;
  logic        ld_pt_we = 1'b0, ld_pt_valid = 1'b0;
  logic [3:0]  ld_pt_vpn = '0;
  logic [7:0]  ld_pt_ppn = '0;
  logic        ld_frame_we = 1'b0;
  logic [7:0]  ld_frame_ppn = '0;

  typedef struct {
    logic [19:0] pa;
    logic        h, m, f;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tlb_xlate uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .ld_tlb_we(ld_tlb_we), .ld_tlb_idx(ld_tlb_idx), .ld_tlb_valid(ld_tlb_valid),
    .ld_tlb_vpn(ld_tlb_vpn), .ld_tlb_ppn(ld_tlb_ppn),
    .ld_pt_we(ld_pt_we), .ld_pt_vpn(ld_pt_vpn), .ld_pt_valid(ld_pt_valid),
    .ld_pt_ppn(ld_pt_ppn),
    .ld_frame_we(ld_frame_we), .ld_frame_ppn(ld_frame_ppn)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R7 unexpected response paddr=%h expected none", rsp_paddr);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_paddr !== e.pa || rsp_hit !== e.h || rsp_miss !== e.m ||
            rsp_fault !== e.f || cyc != e.due) begin
          bad++;
          $display("FAIL %s paddr=%h h=%b m=%b f=%b cyc=%0d expected paddr=%h h=%b m=%b f=%b cyc=%0d",
                   e.tag, rsp_paddr, rsp_hit, rsp_miss, rsp_fault, cyc,
                   e.pa, e.h, e.m, e.f, e.due);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL watchdog run hung, expected completion");
    finish_run();
  end

  task automatic check(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic send(input logic [15:0] va, input logic [19:0] pa,
                      input bit h, input bit m, input bit f, input string tag);
    exp_t e;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    e.pa = pa; e.h = h; e.m = m; e.f = f; e.due = cyc + (h ? 1 : 2); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic load_slot(input logic [1:0] i, input bit v,
                           input logic [3:0] vp, input logic [7:0] pp);
    ld_tlb_we = 1'b1; ld_tlb_idx = i; ld_tlb_valid = v; ld_tlb_vpn = vp; ld_tlb_ppn = pp;
    @(negedge clk);
    ld_tlb_we = 1'b0;
  endtask

  function automatic logic [8:0] pt_init(input int v);
    case (v)
      0:  return {1'b1, 8'd5};
      3:  return {1'b1, 8'd6};
      4:  return {1'b1, 8'd9};
      5:  return {1'b1, 8'd11};
      7:  return {1'b1, 8'd4};
      10: return {1'b1, 8'd3};
      11: return {1'b1, 8'd12};
      default: return 9'd0;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset ready/valid",
          int'({req_ready, rsp_valid}), 2);

    // R10: preload page table, buffer and frame counter
    for (int v = 0; v < 16; v++) begin
      logic [8:0] w;
      w = pt_init(v);
      ld_pt_we = 1'b1; ld_pt_vpn = 4'(v); ld_pt_valid = w[8]; ld_pt_ppn = w[7:0];
      @(negedge clk);
    end
    ld_pt_we = 1'b0;
    load_slot(2'd0, 1'b1, 4'd11, 8'd12);
    load_slot(2'd1, 1'b1, 4'd7,  8'd4);
    load_slot(2'd2, 1'b1, 4'd3,  8'd6);
    load_slot(2'd3, 1'b0, 4'd4,  8'd9);
    ld_frame_we = 1'b1; ld_frame_ppn = 8'd13;
    @(negedge clk);
    ld_frame_we = 1'b0;
    @(negedge clk);

    send(16'h24EC, 20'h0D4EC, 0, 1, 1, "R4 R5 fault fills empty slot 3");
    send(16'h78F4, 20'h048F4, 1, 0, 0, "R2 R10 hit on loaded slot");
    send(16'h4AC0, 20'h09AC0, 0, 1, 0, "R3 resident miss evicts slot 0");
    send(16'hB5A6, 20'h0C5A6, 0, 1, 0, "R6 evicted page misses");
    send(16'h94DE, 20'h0E4DE, 0, 1, 1, "R4 second fault gets next frame");
    send(16'h410D, 20'h0910D, 1, 0, 0, "R3 installed mapping hits");
    send(16'hBD60, 20'h0CD60, 1, 0, 0, "R2 hit refreshes recency");
    send(16'h3001, 20'h06001, 0, 1, 0, "R6 victim after hits");
    send(16'h2FFF, 20'h0DFFF, 0, 1, 0, "R4 page table kept fault frame");
    send(16'h7000, 20'h04000, 0, 1, 0, "R6 oldest slot evicted");
    send(16'h2ABC, 20'h0DABC, 1, 0, 0, "R9 R2 offset passthrough hit");

    // R7: request during page-table cycle is ignored
    begin
      exp_t e;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_vaddr = 16'h4111;
      e.pa = 20'h09111; e.h = 0; e.m = 1; e.f = 0; e.due = cyc + 2; e.tag = "R7 miss before busy";
      q.push_back(e);
      @(negedge clk);
      check(req_ready === 1'b0, "R7 ready low during walk", int'(req_ready), 0);
      req_vaddr = 16'h5222;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R1: reset empties the buffer, table survives
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 ready after second reset",
          int'({req_ready, rsp_valid}), 2);
    send(16'h7123, 20'h04123, 0, 1, 0, "R1 buffer empty after reset");

    // R10: loaded free-frame counter used by next fault
    ld_frame_we = 1'b1; ld_frame_ppn = 8'd40;
    @(negedge clk);
    ld_frame_we = 1'b0;
    @(negedge clk);
    send(16'hC00A, 20'h2800A, 0, 1, 1, "R10 R4 fault uses loaded frame");
    send(16'hC555, 20'h28555, 1, 0, 0, "R4 faulted page now hits");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R7 all expected responses arrived", q.size(), 0);
    finish_run();
  end

endmodule